// File: doc/BRIEF.md
# Half-Bridge Output Enable and Protection Gate

This block sits between the dead-time stage and the two output stages of a half-bridge gate driver. It takes the high-side and low-side commands that have already been spaced apart, and lets each one through only while the driver is enabled and no protection condition is active. The conditions it watches are an enable input, undervoltage on the main bias supply, undervoltage on each of the two driver rails, and over-temperature of the die. Each supply voltage and the die temperature arrive as sampled digital codes. Each code is compared against separate trip and release thresholds, so each detector has hysteresis.

Blocking takes effect at once. The output goes low in the same cycle as the cause, with no register in the cutting path. Release works channel by channel. After a block clears, a channel whose command is already high stays low. It drives again only after its command has been seen low on a clock edge while unblocked, and it then passes the next full pulse. Release of a main-supply undervoltage also needs the supply code to stay good for a set number of consecutive cycles.

Top module: `drv_gate_top`

## Requirements
- R1: While rst_ni is low, and right after it rises, hs_o and ls_o are 0. The three undervoltage status bits read 1 until their release rules are met. The thermal status bit reads 0 during reset.
- R2: With en_i low, hs_o and ls_o are 0 in the same cycle, even in the middle of a command pulse, and fault_o[0] is 1.
- R3: After any block clears, a channel whose command is still high keeps its output at 0. The output follows the command again only after the command has been sampled low on a rising clock edge while that channel was unblocked.
- R4: Main undervoltage trips when vmain_code_i < MAIN_OFF (default 80). fault_o[1] goes to 1 and both outputs go to 0 in that same cycle.
- R5: Main undervoltage clears only after vmain_code_i >= MAIN_ON (default 85) has been sampled on MAIN_REL_CYC+1 consecutive rising edges (default 17). Codes from MAIN_OFF to MAIN_ON-1 hold the present state. A code below MAIN_ON during the wait restarts the count.
- R6: High-rail undervoltage trips when vhi_code_i < RAIL_OFF (default 420) and clears on the first edge that samples vhi_code_i >= RAIL_ON (default 440). It is shown on fault_o[2] and blocks hs_o only.
- R7: Low-rail undervoltage uses the same thresholds on vlo_code_i. It is shown on fault_o[3] and blocks ls_o only.
- R8: Thermal shutdown trips when temp_code_i >= TEMP_TRIP (default 150, in degrees). It clears on the first edge that samples temp_code_i <= TEMP_REL (default 100). It is shown on fault_o[4] and blocks both outputs.
- R9: With no block active and the channel re-armed, each output equals its command in the same cycle.
- R10: The fault_o bits are: bit 0 enable off, bit 1 main undervoltage, bit 2 high-rail undervoltage, bit 3 low-rail undervoltage, bit 4 thermal. A trip shows on its bit in the same cycle as the trip code. A release shows after the clearing edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| en_i | input | 1 | Driver enable |
| hs_cmd_i | input | 1 | High-side command from the dead-time stage |
| ls_cmd_i | input | 1 | Low-side command from the dead-time stage |
| vmain_code_i | input | MAIN_W | Sampled main supply code |
| vhi_code_i | input | RAIL_W | Sampled high-side rail code |
| vlo_code_i | input | RAIL_W | Sampled low-side rail code |
| temp_code_i | input | TEMP_W | Sampled die temperature code |
| hs_o | output | 1 | Gated high-side command |
| ls_o | output | 1 | Gated low-side command |
| fault_o | output | 5 | Per-condition block status |

## Verification
If a detector flag is stuck or wrong, its fault_o bit disagrees with the applied code within one cycle. Two cases are checked: a trip shows in the same cycle as the trip code, and a release lands on one exact edge. The sweeps step through each band of thresholds, so the boundary codes and the hold region are both covered. If the re-arm flag is wrong, a command that was high across a release reaches hs_o or ls_o in the first cycle after the block clears, and the bench watches for exactly that. An off-by-one in the release filter moves the main-undervoltage clear by one edge; the bench counts edges against MAIN_REL_CYC+1 and also restarts the count with one short drop.

// File: rtl/drv_gate_pkg.sv
package drv_gate_pkg;
  localparam int unsigned NFLT      = 5;
  localparam int unsigned FLT_EN    = 0;
  localparam int unsigned FLT_MAIN  = 1;
  localparam int unsigned FLT_HRAIL = 2;
  localparam int unsigned FLT_LRAIL = 3;
  localparam int unsigned FLT_TEMP  = 4;
  localparam int unsigned NCH       = 2;
  localparam int unsigned CH_HS     = 0;
  localparam int unsigned CH_LS     = 1;
  typedef logic [NFLT-1:0] flt_vec_t;
endpackage

// File: rtl/hyst_det.sv
// Threshold detector with hysteresis and optional release qualification.
module hyst_det #(
  parameter int unsigned W          = 8,
  parameter logic [W-1:0] SET_TH    = '0,
  parameter logic [W-1:0] CLR_TH    = '0,
  parameter bit          HIGH_FAULT = 1'b0,
  parameter int unsigned REL_CYC    = 0,
  parameter bit          RST_FAULT  = 1'b1
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] code_i,
  output logic         fault_o
);
  localparam int unsigned CW = (REL_CYC > 0) ? $clog2(REL_CYC + 1) : 1;
  localparam logic [CW-1:0] CNT_END = CW'(REL_CYC);

  logic          trip, clr;
  logic          fault_q;
  logic [CW-1:0] cnt_q;

  generate
    if (HIGH_FAULT) begin : g_high
      assign trip = (code_i >= SET_TH);
      assign clr  = (code_i <= CLR_TH);
    end else begin : g_low
      assign trip = (code_i < SET_TH);
      assign clr  = (code_i >= CLR_TH);
    end
  endgenerate

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      fault_q <= RST_FAULT;
      cnt_q   <= '0;
    end else if (!fault_q) begin
      cnt_q <= '0;
      if (trip) fault_q <= 1'b1;
    end else if (trip || !clr) begin
      cnt_q <= '0;
    end else if (cnt_q == CNT_END) begin
      fault_q <= 1'b0;
      cnt_q   <= '0;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  // trip path bypasses the register so the cut is immediate
  assign fault_o = fault_q | trip;
endmodule

// File: rtl/chan_arm.sv
// Per-channel re-arm: pass only after a low command is seen while unblocked.
module chan_arm (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic blk_i,
  input  logic cmd_i,
  output logic drv_o
);
  logic arm_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)             arm_q <= 1'b0;
    else if (blk_i)          arm_q <= 1'b0;
    else if (!cmd_i)         arm_q <= 1'b1;
  end

  assign drv_o = cmd_i & arm_q & ~blk_i;
endmodule

// File: rtl/drv_gate_top.sv
module drv_gate_top
  import drv_gate_pkg::*;
#(
  parameter int unsigned MAIN_W       = 8,
  parameter int unsigned RAIL_W       = 10,
  parameter int unsigned TEMP_W       = 8,
  parameter int unsigned MAIN_ON      = 85,
  parameter int unsigned MAIN_OFF     = 80,
  parameter int unsigned RAIL_ON      = 440,
  parameter int unsigned RAIL_OFF     = 420,
  parameter int unsigned TEMP_TRIP    = 150,
  parameter int unsigned TEMP_REL     = 100,
  parameter int unsigned MAIN_REL_CYC = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic              hs_cmd_i,
  input  logic              ls_cmd_i,
  input  logic [MAIN_W-1:0] vmain_code_i,
  input  logic [RAIL_W-1:0] vhi_code_i,
  input  logic [RAIL_W-1:0] vlo_code_i,
  input  logic [TEMP_W-1:0] temp_code_i,
  output logic              hs_o,
  output logic              ls_o,
  output logic [NFLT-1:0]   fault_o
);
  logic              main_flt, temp_flt;
  logic [NCH-1:0]    rail_flt;
  logic [RAIL_W-1:0] rail_code [NCH];
  logic [NCH-1:0]    cmd, blk, drv;

  assign rail_code[CH_HS] = vhi_code_i;
  assign rail_code[CH_LS] = vlo_code_i;
  assign cmd[CH_HS]       = hs_cmd_i;
  assign cmd[CH_LS]       = ls_cmd_i;

  hyst_det #(
    .W(MAIN_W), .SET_TH(MAIN_W'(MAIN_OFF)), .CLR_TH(MAIN_W'(MAIN_ON)),
    .HIGH_FAULT(1'b0), .REL_CYC(MAIN_REL_CYC), .RST_FAULT(1'b1)
  ) u_main_uv (
    .clk_i(clk_i), .rst_ni(rst_ni), .code_i(vmain_code_i), .fault_o(main_flt)
  );

  hyst_det #(
    .W(TEMP_W), .SET_TH(TEMP_W'(TEMP_TRIP)), .CLR_TH(TEMP_W'(TEMP_REL)),
    .HIGH_FAULT(1'b1), .REL_CYC(0), .RST_FAULT(1'b0)
  ) u_therm (
    .clk_i(clk_i), .rst_ni(rst_ni), .code_i(temp_code_i), .fault_o(temp_flt)
  );

  generate
    for (genvar c = 0; c < NCH; c++) begin : g_ch
      hyst_det #(
        .W(RAIL_W), .SET_TH(RAIL_W'(RAIL_OFF)), .CLR_TH(RAIL_W'(RAIL_ON)),
        .HIGH_FAULT(1'b0), .REL_CYC(0), .RST_FAULT(1'b1)
      ) u_rail_uv (
        .clk_i(clk_i), .rst_ni(rst_ni), .code_i(rail_code[c]), .fault_o(rail_flt[c])
      );

      assign blk[c] = ~en_i | main_flt | temp_flt | rail_flt[c];

      chan_arm u_arm (
        .clk_i(clk_i), .rst_ni(rst_ni), .blk_i(blk[c]), .cmd_i(cmd[c]), .drv_o(drv[c])
      );
    end
  endgenerate

  assign hs_o = drv[CH_HS];
  assign ls_o = drv[CH_LS];

  always_comb begin
    fault_o            = '0;
    fault_o[FLT_EN]    = ~en_i;
    fault_o[FLT_MAIN]  = main_flt;
    fault_o[FLT_HRAIL] = rail_flt[CH_HS];
    fault_o[FLT_LRAIL] = rail_flt[CH_LS];
    fault_o[FLT_TEMP]  = temp_flt;
  end
endmodule

// File: rtl/drv_gate_chk.sv
module drv_gate_chk #(
  parameter int unsigned MAIN_W   = 8,
  parameter int unsigned RAIL_W   = 10,
  parameter int unsigned TEMP_W   = 8,
  parameter int unsigned MAIN_ON  = 85,
  parameter int unsigned MAIN_OFF = 80
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              en_i,
  input logic              hs_cmd_i,
  input logic              ls_cmd_i,
  input logic [MAIN_W-1:0] vmain_code_i,
  input logic [RAIL_W-1:0] vhi_code_i,
  input logic [RAIL_W-1:0] vlo_code_i,
  input logic [TEMP_W-1:0] temp_code_i,
  input logic              hs_o,
  input logic              ls_o,
  input logic [4:0]        fault_o
);
  always_comb begin
    if (!rst_ni) assert_reset_low_R1: assert (!hs_o && !ls_o);
  end

  assert_disable_cuts_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |-> (!hs_o && !ls_o));

  assert_no_stale_hs_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hs_cmd_i && !hs_o) |=> (!hs_cmd_i || !hs_o));

  assert_no_stale_ls_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ls_cmd_i && !ls_o) |=> (!ls_cmd_i || !ls_o));

  assert_main_trip_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (vmain_code_i < MAIN_W'(MAIN_OFF)) |-> (fault_o[1] && !hs_o && !ls_o));

  assert_main_release_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(fault_o[1]) |-> ($past(vmain_code_i) >= MAIN_W'(MAIN_ON)));

  assert_hrail_gate_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fault_o[2] |-> !hs_o);

  assert_lrail_gate_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fault_o[3] |-> !ls_o);

  assert_therm_gate_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fault_o[4] |-> (!hs_o && !ls_o));
endmodule

bind drv_gate_top drv_gate_chk #(
  .MAIN_W(MAIN_W), .RAIL_W(RAIL_W), .TEMP_W(TEMP_W),
  .MAIN_ON(MAIN_ON), .MAIN_OFF(MAIN_OFF)
) u_chk (.*);

// File: tb/drv_gate_top_bench.sv
`timescale 1ns/1ps
module drv_gate_top_bench;
  localparam int MAIN_ON = 85, MAIN_OFF = 80, RAIL_ON = 440, RAIL_OFF = 420;
  localparam int TEMP_TRIP = 150, TEMP_REL = 100, REL = 16;

  logic       clk_i = 1'b0, rst_ni = 1'b0, en_i = 1'b0;
  logic       hs_cmd_i = 1'b0, ls_cmd_i = 1'b0;
  logic [7:0] vmain_code_i = 8'd120, temp_code_i = 8'd25;
  logic [9:0] vhi_code_i = 10'd500, vlo_code_i = 10'd500;
  logic       hs_o, ls_o;
  logic [4:0] fault_o;

  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;
  bit tr;

  always #10 clk_i = ~clk_i;

  drv_gate_top #(
    .MAIN_ON(MAIN_ON), .MAIN_OFF(MAIN_OFF), .RAIL_ON(RAIL_ON), .RAIL_OFF(RAIL_OFF),
    .TEMP_TRIP(TEMP_TRIP), .TEMP_REL(TEMP_REL), .MAIN_REL_CYC(REL)
  ) u_drv_gate_top (.*);

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic nxt();
    @(negedge clk_i);
  endtask

  task automatic repulse_both();
    nxt(); hs_cmd_i = 1'b0; ls_cmd_i = 1'b0;
    nxt(); hs_cmd_i = 1'b1; ls_cmd_i = 1'b1; #1;
    chk("R3 repulse hs", hs_o, 1); chk("R3 repulse ls", ls_o, 1);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  endtask

  initial begin
    #(200000 * 20);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) nxt(); #1;
    chk("R1 hs", hs_o, 0); chk("R1 ls", ls_o, 0);
    chk("R1 status", fault_o, 5'b01111);

    nxt(); rst_ni = 1'b1;
    for (int k = 1; k <= REL + 4; k++) begin
      nxt(); #1;
      chk("R5 startup filter", fault_o[1], (k <= REL));
      if (k == 1) chk("R6 R7 rails clear", fault_o[3:2], 2'b00);
    end
    en_i = 1'b1; #1;
    chk("R10 all clear", fault_o, 5'b00000);

    // R9: pass-through over all command patterns
    nxt();
    for (int p = 0; p < 4; p++) begin
      nxt(); hs_cmd_i = p[1]; ls_cmd_i = p[0]; #1;
      chk("R9 hs", hs_o, p[1]); chk("R9 ls", ls_o, p[0]);
      nxt(); hs_cmd_i = 1'b0; ls_cmd_i = 1'b0; #1;
      chk("R9 idle", {hs_o, ls_o}, 0);
    end

    // R2 / R3
    nxt(); hs_cmd_i = 1'b1; ls_cmd_i = 1'b1; #1;
    chk("R9 both", {hs_o, ls_o}, 2'b11);
    nxt(); en_i = 1'b0; #1;
    chk("R2 cut", {hs_o, ls_o}, 0); chk("R2 status", fault_o[0], 1);
    nxt(); #1; chk("R2 held", {hs_o, ls_o}, 0);
    nxt(); en_i = 1'b1; #1;
    chk("R3 stale at release", {hs_o, ls_o}, 0);
    for (int k = 0; k < 5; k++) begin
      nxt(); #1; chk("R3 stale held", {hs_o, ls_o}, 0);
    end
    repulse_both();

    // R4: main sweep down
    tr = 1'b0;
    for (int c = 100; c >= 70; c--) begin
      nxt(); vmain_code_i = 8'(c); #1;
      tr = tr | (c < MAIN_OFF);
      chk("R4 main trip", fault_o[1], tr);
      chk("R4 hs gated", hs_o, !tr);
    end
    // R5: hysteresis band holds
    for (int c = 70; c < MAIN_ON; c++) begin
      nxt(); vmain_code_i = 8'(c); nxt(); #1;
      chk("R5 band hold", fault_o[1], 1);
    end
    // R5: interrupted wait restarts count
    nxt(); vmain_code_i = 8'(MAIN_ON);
    repeat (5) nxt();
    vmain_code_i = 8'(MAIN_ON - 1);
    nxt(); vmain_code_i = 8'(MAIN_ON);
    for (int k = 1; k <= REL + 2; k++) begin
      nxt(); #1;
      chk("R5 release count", fault_o[1], (k <= REL));
    end
    chk("R3 stale after uv", {hs_o, ls_o}, 0);
    repulse_both();

    // R6: high rail
    tr = 1'b0;
    for (int c = 450; c >= 400; c--) begin
      nxt(); vhi_code_i = 10'(c); #1;
      tr = tr | (c < RAIL_OFF);
      chk("R6 hrail trip", fault_o[2], tr);
      chk("R6 hs gated", hs_o, !tr);
      chk("R6 ls untouched", ls_o, 1);
    end
    for (int c = 400; c < RAIL_ON; c++) begin
      nxt(); vhi_code_i = 10'(c); nxt(); #1;
      chk("R6 band hold", fault_o[2], 1);
    end
    nxt(); vhi_code_i = 10'(RAIL_ON); #1;
    chk("R6 not yet released", fault_o[2], 1);
    nxt(); #1;
    chk("R6 released", fault_o[2], 0);
    chk("R3 hs stale after rail", hs_o, 0);
    repulse_both();

    // R7: low rail
    tr = 1'b0;
    for (int c = 450; c >= 400; c--) begin
      nxt(); vlo_code_i = 10'(c); #1;
      tr = tr | (c < RAIL_OFF);
      chk("R7 lrail trip", fault_o[3], tr);
      chk("R7 ls gated", ls_o, !tr);
      chk("R7 hs untouched", hs_o, 1);
    end
    for (int c = 400; c < RAIL_ON; c++) begin
      nxt(); vlo_code_i = 10'(c); nxt(); #1;
      chk("R7 band hold", fault_o[3], 1);
    end
    nxt(); vlo_code_i = 10'(RAIL_ON);
    nxt(); #1;
    chk("R7 released", fault_o[3], 0);
    chk("R3 ls stale after rail", ls_o, 0);
    repulse_both();

    // R8: thermal
    tr = 1'b0;
    for (int c = 140; c <= 160; c++) begin
      nxt(); temp_code_i = 8'(c); #1;
      tr = tr | (c >= TEMP_TRIP);
      chk("R8 therm trip", fault_o[4], tr);
      chk("R8 both gated", {hs_o, ls_o}, tr ? 2'b00 : 2'b11);
    end
    for (int c = 160; c > TEMP_REL; c--) begin
      nxt(); temp_code_i = 8'(c); nxt(); #1;
      chk("R8 band hold", fault_o[4], 1);
    end
    nxt(); temp_code_i = 8'(TEMP_REL);
    nxt(); #1;
    chk("R8 released", fault_o[4], 0);
    chk("R10 final status", fault_o, 5'b00000);
    repulse_both();

    finish_run();
  end
endmodule